// File: doc/BRIEF.md
# Device-Interleaved SEC-DED Memory Codec

This block sits between a 256-bit data path and a memory built from 4-bit-wide storage devices. On the write side it splits the data into four 64-bit words and extends each with eight check bits. The result is four 72-bit codewords, which it spreads over 72 device slots. Every slot carries one bit from each of the four codewords. A hard fault that wipes out a whole device therefore costs each codeword only one bit, and each codeword repairs that bit on its own.

On the read side the block takes the 288-bit device image and regroups it into the four codewords. For each codeword it computes a 7-bit Hamming syndrome and an overall parity bit. It flips a single faulty bit back and marks a double error as unrepairable. Corrected data and a 2-bit status per codeword appear one clock after the read strobe. When all four codewords were repaired at the same slot, a device-fault flag is raised together with that slot's number, so a monitoring agent can name the failed device.

Top module: `ecc_ilv_codec`

## Requirements
- R1: Codeword layout. Position 0 holds even parity over all 72 bits. Positions 1, 2, 4, 8, 16, 32 and 64 hold Hamming check bits. Data bit i sits at the i-th remaining position in ascending order. `wr_dev[4*d+j]` carries bit d of codeword j, and codeword j encodes `wr_data[64*j +: 64]`. The encode path is combinational.
- R2: A device image that carries no error reads back the original data with every status field equal to 00.
- R3: A single flipped bit anywhere in a codeword is repaired, including a flip in a check bit or in the parity bit. That codeword reports 01 and the other codewords report 00.
- R4: Two flipped bits in one codeword give status 10 for that codeword. The other codewords still return correct data with status 00. The value 11 never appears in any field.
- R5: Any one device stuck at any nibble value still yields the original 256 data bits.
- R6: `dev_fault` is 1 only when all four codewords report 01 with the same error position. In that case `dev_fault_slot` gives the slot number; otherwise both outputs are 0.
- R7: `out_valid` follows `rd_valid` by exactly one clock. While `rd_valid` is low, `rd_data_q`, `rd_status`, `dev_fault` and `dev_fault_slot` hold their values.
- R8: After reset, `out_valid`, `rd_data_q`, `rd_status`, `dev_fault` and `dev_fault_slot` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 256 | Write data, word j in bits 64j..64j+63 |
| wr_dev | output | 288 | Encoded device image, slot d in bits 4d..4d+3 |
| rd_valid | input | 1 | Read strobe qualifying rd_dev |
| rd_dev | input | 288 | Device image read back from memory |
| rd_data_q | output | 256 | Corrected read data |
| rd_status | output | 8 | Status of codeword j in bits 2j+1:2j (00 clean, 01 corrected, 10 uncorrectable) |
| out_valid | output | 1 | Registered read strobe |
| dev_fault | output | 1 | Whole-device fault detected |
| dev_fault_slot | output | 7 | Slot number of the faulty device |

## Verification
The hardest case to reach from the ports is the device-fault flag. It needs a read in which all four codewords are hit at the same slot. A stuck device produces this only when its stuck value differs from every bit it should hold. The bench visits every slot twice. In the first pass it replaces the nibble with the complement of the true one, which forces the flag. In the second pass it forces the nibble to zero, which raises the flag only where the stored nibble was all ones. This exercises both the flagged and the partial cases at every position.

// File: rtl/ecc_ilv_codec.sv
module ecc_ilv_codec #(
  parameter int DEV_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEV_W*DATA_W-1:0]   wr_data,
  output logic [DEV_W*(DATA_W+$clog2(DATA_W)+2)-1:0] wr_dev,
  input  logic                      rd_valid,
  input  logic [DEV_W*(DATA_W+$clog2(DATA_W)+2)-1:0] rd_dev,
  output logic [DEV_W*DATA_W-1:0]   rd_data_q,
  output logic [2*DEV_W-1:0]        rd_status,
  output logic                      out_valid,
  output logic                      dev_fault,
  output logic [$clog2(DATA_W)+0:0] dev_fault_slot
);
  localparam int CHK_W = $clog2(DATA_W) + 1;
  localparam int CW_W  = DATA_W + CHK_W + 1;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CHK_W-1:0] syn_of(input logic [CW_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p < CW_W; p++)
      if (c[p]) s ^= CHK_W'(p);
    return s;
  endfunction

  function automatic logic [CW_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] c;
    logic [CHK_W-1:0] s;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++)
      if (!is_pow2(p)) begin
        c[p] = d[k];
        k++;
      end
    s = syn_of(c);
    for (int b = 0; b < CHK_W; b++) c[1 << b] = s[b];
    c[0] = ^c[CW_W-1:1];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] extract(input logic [CW_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++)
      if (!is_pow2(p)) begin
        d[k] = c[p];
        k++;
      end
    return d;
  endfunction

  logic [DEV_W*DATA_W-1:0] dec_data;
  logic [2*DEV_W-1:0]      dec_st;
  logic [CHK_W-1:0]        dec_pos [DEV_W];
  logic                    fault_c;

  for (genvar j = 0; j < DEV_W; j++) begin : g_word
    logic [CW_W-1:0]  cw_w, cw_r, cw_fix;
    logic [CHK_W-1:0] syn;
    logic             par;
    logic [1:0]       st;

    assign cw_w = encode(wr_data[j*DATA_W +: DATA_W]);
    for (genvar d = 0; d < CW_W; d++) begin : g_slot
      assign wr_dev[d*DEV_W + j] = cw_w[d];
      assign cw_r[d]             = rd_dev[d*DEV_W + j];
    end

    assign syn = syn_of(cw_r);
    assign par = ^cw_r;

    always_comb begin
      cw_fix = cw_r;
      st     = 2'b00;
      if (par) begin
        if (int'(syn) < CW_W) begin
          cw_fix[syn] = ~cw_r[syn];
          st          = 2'b01;
        end else begin
          st = 2'b10;
        end
      end else if (syn != '0) begin
        st = 2'b10;
      end
    end

    assign dec_data[j*DATA_W +: DATA_W] = extract(cw_fix);
    assign dec_st[2*j +: 2]             = st;
    assign dec_pos[j]                   = syn;
  end

  always_comb begin
    fault_c = 1'b1;
    for (int j = 0; j < DEV_W; j++)
      if (dec_st[2*j +: 2] != 2'b01 || dec_pos[j] != dec_pos[0]) fault_c = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      rd_data_q      <= '0;
      rd_status      <= '0;
      dev_fault      <= 1'b0;
      dev_fault_slot <= '0;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) begin
        rd_data_q      <= dec_data;
        rd_status      <= dec_st;
        dev_fault      <= fault_c;
        dev_fault_slot <= fault_c ? dec_pos[0] : '0;
      end
    end
  end
endmodule

module ecc_ilv_codec_chk #(
  parameter int DEV_W  = 4,
  parameter int DATA_W = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DEV_W*DATA_W-1:0] wr_data,
  input logic [DEV_W*(DATA_W+$clog2(DATA_W)+2)-1:0] wr_dev,
  input logic                    rd_valid,
  input logic [DEV_W*(DATA_W+$clog2(DATA_W)+2)-1:0] rd_dev,
  input logic [DEV_W*DATA_W-1:0] rd_data_q,
  input logic [2*DEV_W-1:0]      rd_status,
  input logic                    out_valid,
  input logic                    dev_fault
);
  p_roundtrip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && (rd_dev == wr_dev) |=> (rd_status == '0) && (rd_data_q == $past(wr_data)));

  for (genvar j = 0; j < DEV_W; j++) begin : g_code
    p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status[2*j +: 2] != 2'b11);
  end

  p_fault_all_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fault |-> rd_status == {DEV_W{2'b01}});

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid && $stable(rd_data_q) && $stable(rd_status) && $stable(dev_fault));
endmodule

bind ecc_ilv_codec ecc_ilv_codec_chk #(.DEV_W(DEV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_dev(wr_dev),
  .rd_valid(rd_valid), .rd_dev(rd_dev), .rd_data_q(rd_data_q),
  .rd_status(rd_status), .out_valid(out_valid), .dev_fault(dev_fault)
);

// File: tb/ecc_ilv_codec_bench.sv
module ecc_ilv_codec_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] wr_data = '0;
  logic [287:0] wr_dev;
  logic         rd_valid = 1'b0;
  logic [287:0] rd_dev = '0;
  logic [255:0] rd_data_q;
  logic [7:0]   rd_status;
  logic         out_valid;
  logic         dev_fault;
  logic [6:0]   dev_fault_slot;

  int n_tot = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_ilv_codec u_ecc_ilv_codec (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_dev(wr_dev),
    .rd_valid(rd_valid), .rd_dev(rd_dev), .rd_data_q(rd_data_q),
    .rd_status(rd_status), .out_valid(out_valid), .dev_fault(dev_fault),
    .dev_fault_slot(dev_fault_slot)
  );

  function automatic logic [71:0] b_enc(input logic [63:0] d);
    logic [71:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < 72; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    for (int b = 0; b < 7; b++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < 72; p++)
        if (((p >> b) & 1) == 1 && (p & (p - 1)) != 0) x ^= c[p];
      c[1 << b] = x;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [287:0] b_image(input logic [255:0] d);
    logic [287:0] r;
    for (int j = 0; j < 4; j++) begin
      logic [71:0] c;
      c = b_enc(d[64*j +: 64]);
      for (int s = 0; s < 72; s++) r[4*s + j] = c[s];
    end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [287:0] dv);
    @(negedge clk);
    rd_dev   = dv;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tot++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
      $finish;
    end
  end

  initial begin
    logic [255:0] d;
    logic [287:0] img;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && rd_data_q == 0 && rd_status == 0 && dev_fault == 0 && dev_fault_slot == 0,
        "R8 reset state", {rd_status, 1'b0, dev_fault_slot}, 0);
    rst_n = 1'b1;

    // R1 and R2: encode layout and clean round trip
    for (int t = 0; t < 10; t++) begin
      d = (t == 0) ? '0 : (t == 1) ? '1 : (t < 6) ? (256'h1 << (t * 61)) : rnd256();
      wr_data = d;
      #1;
      chk(wr_dev == b_image(d), "R1 encode layout", wr_dev, b_image(d));
      do_read(wr_dev);
      chk(out_valid == 1'b1, "R7 out_valid one cycle later", out_valid, 1);
      chk(rd_data_q == d && rd_status == 0 && !dev_fault, "R2 clean read", rd_data_q, d);
    end

    // R7: hold while no strobe
    @(negedge clk);
    rd_dev = ~rd_dev;
    repeat (3) @(negedge clk);
    chk(!out_valid && rd_data_q == d && rd_status == 0, "R7 hold without strobe", rd_data_q, d);

    // R3: every single bit of the image
    d = rnd256();
    img = b_image(d);
    for (int b = 0; b < 288; b++) begin
      do_read(img ^ (288'h1 << b));
      chk(rd_data_q == d, "R3 single bit data", rd_data_q, d);
      chk(rd_status == (8'h1 << (2 * (b % 4))) && !dev_fault, "R3 single bit status",
          {rd_status, dev_fault}, {8'h1 << (2 * (b % 4)), 1'b0});
    end

    // R4: double errors within one codeword
    for (int j = 0; j < 4; j++)
      for (int a = 0; a < 72; a++) begin
        int b2;
        logic [255:0] m;
        b2 = (a + 37) % 72;
        d = rnd256();
        img = b_image(d) ^ (288'h1 << (4 * a + j)) ^ (288'h1 << (4 * b2 + j));
        m = ~(256'hFFFF_FFFF_FFFF_FFFF << (64 * j));
        do_read(img);
        chk(rd_status == (8'h2 << (2 * j)) && !dev_fault, "R4 double status",
            {rd_status, dev_fault}, {8'h2 << (2 * j), 1'b0});
        chk((rd_data_q & m) == (d & m), "R4 other words intact", rd_data_q & m, d & m);
      end

    // R5 and R6: whole device stuck
    for (int v = 0; v < 2; v++)
      for (int s = 0; s < 72; s++) begin
        logic [3:0] orig, bad;
        logic [7:0] est;
        logic       ef;
        d = rnd256();
        img = b_image(d);
        orig = img[4*s +: 4];
        bad  = (v == 0) ? ~orig : 4'h0;
        img[4*s +: 4] = bad;
        est = '0;
        for (int j = 0; j < 4; j++) if (orig[j] != bad[j]) est[2*j] = 1'b1;
        ef = (orig ^ bad) == 4'hF;
        do_read(img);
        chk(rd_data_q == d, "R5 device fault recovered", rd_data_q, d);
        chk(rd_status == est, "R5 device fault status", rd_status, est);
        chk(dev_fault == ef && dev_fault_slot == (ef ? 7'(s) : 7'd0), "R6 fault flag and slot",
            {dev_fault, dev_fault_slot}, {ef, ef ? 7'(s) : 7'd0});
      end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule